// File: doc/BRIEF.md
# Multi-format serial audio receiver

The block takes a stereo audio stream on three asynchronous wires (bit clock, word select and serial data) and turns it into parallel left and right samples in the system clock domain. All three wires pass through a two-flop synchronizer. The block samples them on each rising bit-clock edge that it detects in the system clock domain. Word select runs continuously, and its rate is the sample rate. That rate may lie anywhere from about 5 kHz to 55 kHz, so no fixed rate or fixed frame length is assumed. Frame boundaries come only from word-select transitions.

Four frame formats can be selected. In the one-bit-delayed MSB-first format (I2S), the word starts one bit clock after each word-select transition. In the three LSB-justified formats, the sample is the last 16, 18 or 20 bits before the next word-select transition. Every sample is presented as a 24-bit word. Left and right come out together with a single-cycle strobe once per frame. A new format setting takes effect only at the start of a left word. A lock flag shows whether word select is still toggling within a programmable number of system clock cycles.

Top module: `audio_serial_rx`

## Requirements
- R1: `fmt_i` selects the frame format: 0 = I2S, 1 = LSB-justified 16 bits, 2 = LSB-justified 18 bits, 3 = LSB-justified 20 bits. Serial inputs are sampled on rising bit-clock edges after a two-flop synchronizer. The first rising edge after reset only records the word-select level.
- R2: In I2S format, word select low marks the left word and high marks the right word. Word bits start at the rising bit-clock edge that follows the one showing the new word-select level, and they continue through the edge showing the next transition, MSB first. The first 24 bits are output left-aligned. Shorter words are zero-filled in the low bits, and bits after the 24th are dropped.
- R3: In the LSB-justified formats, the sample is the last N bits (N = 16, 18 or 20) sampled before the rising edge that shows the next word-select transition. Bits earlier in that half-frame have no effect on the output.
- R4: LSB-justified samples are sign-extended from bit N-1 to 24 bits.
- R5: `valid_o` is a one-cycle pulse. It is raised once per frame when the right word ends, which is at the rising edge showing word select going from high to low. `left_o` and `right_o` are updated together with the pulse and hold their values at all other times.
- R6: The format is latched from `fmt_i` only at the high-to-low word-select transition that starts a left word. A change during a frame does not affect that frame's right word.
- R7: A strobe is issued only for a frame whose left word ended at a low-to-high word-select transition after the previous strobe (or after reset). The first partial frame after reset yields no strobe.
- R8: `locked_o` is 0 after reset. It goes to 1 within a few cycles of any word-select transition and drops to 0 once no transition has been seen for more than `timeout_i` system clock cycles.
- R9: During and right after reset, `valid_o` is 0 and `left_o` and `right_o` are all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial bit clock, asynchronous |
| ws_i | input | 1 | Word select, asynchronous |
| sd_i | input | 1 | Serial data, asynchronous |
| fmt_i | input | 2 | Frame format select (see R1) |
| timeout_i | input | TO_W (16) | Lock timeout in system clock cycles |
| left_o | output | 24 | Left sample, signed, 24 bits |
| right_o | output | 24 | Right sample, signed, 24 bits |
| valid_o | output | 1 | One-cycle strobe per stereo pair |
| locked_o | output | 1 | Word select is toggling within the timeout |

## Verification
The hardest situation to reach is a format switch between frames. At that boundary, the bit on the transition edge belongs to a word in the old format, while the half-frame that follows is decoded in the new one. An I2S word's last bit can then land in the ignored prefix of an LSB-justified half, or a justified word can be followed by an I2S word. The stimulus builds the serial stream from a model that carries that trailing bit across every half-frame. It changes `fmt_i` in the middle of random frames with random half-frame lengths from the minimum to 32 bits. Directed frames cover the extreme negative and positive justified samples, I2S words shorter and longer than 24 bits, and the shortest legal justified half.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;
  localparam int OUT_W   = 24;
  localparam int LSB_MAX = 20;

  typedef enum logic [1:0] {
    FMT_I2S   = 2'd0,
    FMT_LSB16 = 2'd1,
    FMT_LSB18 = 2'd2,
    FMT_LSB20 = 2'd3
  } fmt_e;

  function automatic logic [OUT_W-1:0] sext_lsb(input logic [LSB_MAX-1:0] sr, input fmt_e f);
    logic [OUT_W-1:0] r;
    case (f)
      FMT_LSB16: r = {{(OUT_W-16){sr[15]}}, sr[15:0]};
      FMT_LSB18: r = {{(OUT_W-18){sr[17]}}, sr[17:0]};
      default:   r = {{(OUT_W-20){sr[19]}}, sr[19:0]};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sync_ff.sv
module sync_ff #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '0;
      else         chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/rx_frontend.sv
module rx_frontend #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic ws_i,
  input  logic sd_i,
  output logic bit_stb_o,
  output logic bit_o,
  output logic ws_edge_o,
  output logic ws_fall_o,
  output logic ws_chg_o
);
  logic [2:0] sync_q;
  logic sck_s, ws_s, sd_s;
  logic sck_d, ws_d, ws_bit_prev, primed;

  sync_ff #(.W(3), .STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, ws_i, sd_i}),
    .q_o   (sync_q)
  );

  assign {sck_s, ws_s, sd_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d       <= 1'b0;
      ws_d        <= 1'b0;
      ws_bit_prev <= 1'b0;
      primed      <= 1'b0;
    end else begin
      sck_d <= sck_s;
      ws_d  <= ws_s;
      if (bit_stb_o) begin
        primed      <= 1'b1;
        ws_bit_prev <= ws_s;
      end
    end
  end

  assign bit_stb_o = sck_s & ~sck_d;
  assign bit_o     = sd_s;
  assign ws_edge_o = bit_stb_o & primed & (ws_s ^ ws_bit_prev);
  // previous level high: right word just ended
  assign ws_fall_o = ws_edge_o & ws_bit_prev;
  assign ws_chg_o  = ws_s ^ ws_d;
endmodule

// File: rtl/word_capture.sv
module word_capture
  import audio_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_stb_i,
  input  logic             bit_i,
  input  logic             edge_i,
  input  fmt_e             fmt_i,
  output logic [OUT_W-1:0] word_o
);
  localparam int CW = $clog2(OUT_W + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(OUT_W);
  localparam logic [OUT_W-1:0] TOP_BIT = {1'b1, {(OUT_W-1){1'b0}}};

  logic [OUT_W-1:0]   acc, acc_nx;
  logic [CW-1:0]      cnt;
  logic [LSB_MAX-1:0] sr;

  // MSB-first accumulator: the bit on the edge strobe still belongs to the ending word
  always_comb begin
    acc_nx = acc;
    if (cnt < CNT_MAX && bit_i) acc_nx = acc | (TOP_BIT >> cnt);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc <= '0;
      cnt <= '0;
      sr  <= '0;
    end else if (bit_stb_i) begin
      sr <= {sr[LSB_MAX-2:0], bit_i};
      if (edge_i) begin
        acc <= '0;
        cnt <= '0;
      end else begin
        acc <= acc_nx;
        if (cnt < CNT_MAX) cnt <= cnt + 1'b1;
      end
    end
  end

  // justified word excludes the bit sampled on the edge strobe
  assign word_o = (fmt_i == FMT_I2S) ? acc_nx : sext_lsb(sr, fmt_i);
endmodule

// File: rtl/lock_monitor.sv
module lock_monitor #(
  parameter int TO_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ws_chg_i,
  input  logic [TO_W-1:0] timeout_i,
  output logic            locked_o
);
  logic [TO_W-1:0] idle_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_cnt <= '0;
      locked_o <= 1'b0;
    end else if (ws_chg_i) begin
      idle_cnt <= '0;
      locked_o <= 1'b1;
    end else begin
      if (idle_cnt != '1) idle_cnt <= idle_cnt + 1'b1;
      if (idle_cnt >= timeout_i) locked_o <= 1'b0;
    end
  end
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import audio_rx_pkg::*;
#(
  parameter int TO_W   = 16,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_i,
  input  logic             ws_i,
  input  logic             sd_i,
  input  logic [1:0]       fmt_i,
  input  logic [TO_W-1:0]  timeout_i,
  output logic [OUT_W-1:0] left_o,
  output logic [OUT_W-1:0] right_o,
  output logic             valid_o,
  output logic             locked_o
);
  logic bit_stb, bit_val, ws_edge, fall_stb, rise_stb, ws_chg;
  logic have_left;
  fmt_e fmt_q;
  logic [OUT_W-1:0] word, left_hold;

  rx_frontend #(.STAGES(STAGES)) u_front (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sck_i    (sck_i),
    .ws_i     (ws_i),
    .sd_i     (sd_i),
    .bit_stb_o(bit_stb),
    .bit_o    (bit_val),
    .ws_edge_o(ws_edge),
    .ws_fall_o(fall_stb),
    .ws_chg_o (ws_chg)
  );

  word_capture u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_stb_i(bit_stb),
    .bit_i    (bit_val),
    .edge_i   (ws_edge),
    .fmt_i    (fmt_q),
    .word_o   (word)
  );

  lock_monitor #(.TO_W(TO_W)) u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ws_chg_i (ws_chg),
    .timeout_i(timeout_i),
    .locked_o (locked_o)
  );

  assign rise_stb = ws_edge & ~fall_stb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_q     <= FMT_I2S;
      have_left <= 1'b0;
      left_hold <= '0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (rise_stb) begin
        left_hold <= word;
        have_left <= 1'b1;
      end
      if (fall_stb) begin
        fmt_q     <= fmt_e'(fmt_i);
        have_left <= 1'b0;
        if (have_left) begin
          left_o  <= left_hold;
          right_o <= word;
          valid_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/audio_serial_rx_chk.sv
module audio_serial_rx_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_o,
  input logic [23:0] left_o,
  input logic [23:0] right_o,
  input logic        locked_o,
  input logic        fall_stb,
  input logic        ws_chg,
  input logic [1:0]  fmt_q,
  input logic [1:0]  fmt_i
);
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R5
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(left_o) && $stable(right_o))); // R5
  AST_VALID_AT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(fall_stb)); // R7
  AST_FMT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_stb |=> $stable(fmt_q)); // R6
  AST_FMT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_stb |=> (fmt_q == $past(fmt_i))); // R6
  AST_LOCK_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(ws_chg)); // R8
endmodule

bind audio_serial_rx audio_serial_rx_chk u_chk (.*);

// File: tb/audio_serial_rx_test.sv
module audio_serial_rx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0, ws = 1'b0, sd = 1'b0;
  logic [1:0]  fmt = 2'd0;
  logic [15:0] tmo = 16'd1000;
  logic [23:0] left_o, right_o;
  logic        valid_o, locked_o;

  int n_chk = 0, n_bad = 0, n_valid = 0, n_frames = 0;
  logic carry = 1'b0;
  logic [23:0] exp_q[$];
  string       tag_q[$];
  logic [23:0] last_l = '0;

  always #2 clk = ~clk;

  audio_serial_rx uut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .ws_i(ws), .sd_i(sd),
    .fmt_i(fmt), .timeout_i(tmo),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o), .locked_o(locked_o)
  );

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic w, input logic b);
    @(negedge clk);
    ws = w; sd = b;
    repeat (4) @(negedge clk);
    sck = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b0;
  endtask

  function automatic int width_of(input logic [1:0] f);
    return 14 + 2 * int'(f);
  endfunction

  // one half-frame; position 0 always carries the trailing bit of the previous word
  task automatic send_half(input logic w, input logic [1:0] f, input int h,
                           input logic use_v, input logic [23:0] v, output logic [23:0] e);
    logic [31:0] r;
    logic [23:0] m, s;
    int n;
    if (f == 2'd0) begin
      r = use_v ? {v, 8'($urandom)} : $urandom;
      e = '0;
      for (int i = 0; i < h && i < 24; i++) e[23-i] = r[31-i];
      send_bit(w, carry);
      for (int p = 1; p < h; p++) send_bit(w, r[31-(p-1)]);
      carry = r[31-(h-1)];
    end else begin
      n = width_of(f);
      r = use_v ? {8'd0, v} : $urandom;
      m = (24'd1 << n) - 24'd1;
      s = r[23:0] & m;
      e = s[n-1] ? (s | ~m) : s;
      send_bit(w, carry);
      for (int p = 1; p < h - n; p++) send_bit(w, 1'($urandom));
      for (int k = n - 1; k >= 0; k--) send_bit(w, s[k]);
      carry = 1'($urandom);
    end
  endtask

  function automatic string tag_for(input logic [1:0] f, input logic [23:0] e);
    if (f == 2'd0) return "R2";
    return e[23] ? "R4" : "R3";
  endfunction

  task automatic frame(input logic [1:0] fl, input logic [1:0] fn, input int hl, input int hr,
                       input logic use_v, input logic [23:0] vl, input logic [23:0] vr);
    logic [23:0] el, er;
    send_half(1'b0, fl, hl, use_v, vl, el);
    exp_q.push_back(el); tag_q.push_back(tag_for(fl, el));
    fmt = fn;
    send_half(1'b1, fl, hr, use_v, vr, er);
    exp_q.push_back(er); tag_q.push_back((fn != fl) ? "R6" : tag_for(fl, er));
    last_l = el;
    n_frames++;
  endtask

  function automatic int rand_h(input logic [1:0] f);
    if (f == 2'd0) return 16 + int'($urandom_range(16, 0));
    return width_of(f) + 1 + int'($urandom_range(31 - width_of(f), 0));
  endfunction

  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      n_valid++;
      if (exp_q.size() < 2) begin
        n_chk++; n_bad++;
        $display("FAIL R7 unexpected strobe act=%h exp=none", left_o);
      end else begin
        logic [23:0] el, er;
        string tl, tr;
        el = exp_q.pop_front(); tl = tag_q.pop_front();
        er = exp_q.pop_front(); tr = tag_q.pop_front();
        check({tl, " left"}, left_o, el);
        check({tr, " right"}, right_o, er);
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [1:0] f, fn;
    logic [23:0] dummy;
    void'($urandom(32'h5eed_1335));
    repeat (5) @(negedge clk);
    check("R9 valid", 24'(valid_o), 24'd0);
    check("R9 left", left_o, 24'd0);
    check("R9 right", right_o, 24'd0);
    check("R8 reset lock", 24'(locked_o), 24'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 after reset", {left_o[22:0], valid_o}, 24'd0);

    // preamble: partial right half, first strobe must be suppressed (R7, R1 priming)
    fmt = 2'd0;
    for (int i = 0; i < 10; i++) send_bit(1'b1, 1'($urandom));

    // directed corners
    frame(2'd0, 2'd0, 24, 24, 1'b1, 24'h800001, 24'h7ffffe);
    frame(2'd0, 2'd0, 16, 32, 1'b1, 24'hA5C3FF, 24'h123456);
    frame(2'd0, 2'd1, 25, 17, 1'b0, '0, '0);
    frame(2'd1, 2'd1, 17, 32, 1'b1, 24'h008000, 24'h007fff);
    frame(2'd1, 2'd3, 20, 20, 1'b1, 24'h00ffff, 24'h000001);
    frame(2'd3, 2'd2, 21, 32, 1'b1, 24'h080000, 24'h07ffff);
    frame(2'd2, 2'd0, 19, 30, 1'b1, 24'h020000, 24'h01ffff);
    frame(2'd0, 2'd2, 31, 17, 1'b0, '0, '0);

    // random frames with random format changes
    f = 2'd2;
    for (int k = 0; k < 40; k++) begin
      fn = ($urandom_range(3, 0) == 0) ? 2'($urandom_range(3, 0)) : f;
      frame(f, fn, rand_h(f), rand_h(f), 1'b0, '0, '0);
      f = fn;
    end

    // trailing left half releases the last strobe; its own word is never paired
    send_half(1'b0, f, 24, 1'b0, '0, dummy);
    ws = 1'b1;                       // word-select toggle without bit clock
    repeat (200) @(negedge clk);
    check("R8 locked within timeout", 24'(locked_o), 24'd1);
    check("R7 strobe count", 24'(n_valid), 24'(n_frames));
    check("R5 left held", left_o, last_l);
    check("R7 nothing pending", 24'(exp_q.size()), 24'd0);
    repeat (1100) @(negedge clk);
    check("R8 lock lost", 24'(locked_o), 24'd0);
    check("R5 no spurious strobe", 24'(n_valid), 24'(n_frames));
    ws = 1'b0;
    repeat (10) @(negedge clk);
    check("R8 lock regained", 24'(locked_o), 24'd1);
    tmo = 16'd20;
    repeat (40) @(negedge clk);
    check("R8 short timeout", 24'(locked_o), 24'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule